// File: doc/BRIEF.md
# Two-out-of-three safety trip voter

This block decides whether a plant must shut down. It takes three trip-request lines from redundant threshold monitors. Each line is fail-safe: a high level means the channel is healthy, and a low level means the channel wants a trip. A broken wire or a dead monitor therefore reads as a request. Each line passes through a two-flop synchroniser. A trip is declared when at least two of the three synchronised lines are low. The block drives a single run-permit output. That output is high only while the plant may run. Shutdown logic downstream treats any loss of the permit as an unconditional shutdown.

A declared trip is latched. The permit stays low until a reset request arrives while all three channels read healthy. Every start passes through a startup phase: after a reset, or after an accepted trip reset, the permit is held low until all three channels have read healthy for a set number of consecutive cycles.

Two further functions watch the channels and the trip path. For each channel, a sticky flag records a channel that disagreed with the other two for too long. A deadline monitor counts how long the permit stays high while a trip condition is present. All of this goes out on a status word. The status word is output only, so nothing on the display side can reach the voter state.

Top module: `trip_voter`

## Requirements
- R1: Each `chan_ok_i` bit (bit 0 = channel 0) is synchronised through two flops. Status bits [5:3] (bit 3 = channel 0) show the synchronised health levels. A change at an input appears there after the second rising edge.
- R2: When two or three synchronised channels are low while running, the permit falls after the third rising edge following the input change. This is well within the deadline budget. Every pair of channels and all three together cause a trip.
- R3: A single low channel never drops the permit, however long it stays low.
- R4: A declared trip is latched. The permit stays low and the state code in status bits [2:1] reads 2'b10 (tripped) after the channels recover.
- R5: `trip_reset_i` is accepted only on a cycle when all three synchronised channels are high. Otherwise it has no effect. An accepted reset in the tripped state moves to startup (code 2'b00).
- R6: After `rst_n` or an accepted trip reset, the permit stays low until all three synchronised channels have been high for STARTUP_CYCLES consecutive cycles. The state code then reads 2'b01 (run). Any low channel during startup restarts the count.
- R7: A channel that differs from the other two, while those two agree, for DISC_CYCLES consecutive cycles sets its sticky flag in status bits [8:6] (bit 6 = channel 0). A shorter disagreement sets nothing. Flags clear only on `rst_n` or an accepted trip reset.
- R8: The deadline monitor counts cycles in which the permit is high while a trip condition is present. If the count reaches DEADLINE_CYCLES, it sets sticky status bit 9. In correct operation this bit stays 0.
- R9: During reset the permit is low and the whole status word is zero.
- R10: A trip reset request while running does not disturb the permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_ok_i | input | 3 | Channel health, high = healthy, low = trip request |
| trip_reset_i | input | 1 | Request to clear a latched trip |
| run_permit_o | output | 1 | Energise-to-hold run permit |
| status_o | output | 10 | Read-only status word: permit, state, synchronised health, discrepancy flags, overrun |

## Verification
The bench covers several corner cases. Each is listed with the fault it exposes.

- **Trip latency.** It samples the permit on each of the three edges after two channels drop. An extra register would let the permit stay high one edge too long, and a missing synchroniser stage would let it fall one edge early.
- **Every channel pair and all three together.** It trips on each pair and on all three. A voter that miscounts would ignore one of these patterns.
- **Trip latch and reset gating.** It restores the channels and then issues a reset while one channel is still low. A design that does not latch, or that does not gate the reset, would show the permit returning or a premature move to startup.
- **Interrupted startup.** It drops one channel for a single cycle during startup. A design that does not restart its count would raise the permit early.
- **Long and short disagreements.** It holds one channel low for a long time and glitches another briefly. This catches a single-channel trip, a flag that is not sticky, and a flag set by a glitch shorter than DISC_CYCLES.

// File: rtl/tv_pkg.sv
// Package tv_pkg
// Shared types and status-word layout for the two-out-of-three trip voter.
// Assumes exactly three channels; the vote is written for that count.
package tv_pkg;

    localparam int NCH      = 3;
    localparam int STATUS_W = 10;

    // Status word bit positions
    localparam int SB_PERMIT = 0;
    localparam int SB_STATE  = 1;   // two bits
    localparam int SB_HEALTH = 3;   // NCH bits
    localparam int SB_DISC   = 6;   // NCH bits
    localparam int SB_OVR    = 9;

    typedef enum logic [1:0] {
        ST_START = 2'b00,
        ST_RUN   = 2'b01,
        ST_TRIP  = 2'b10
    } tv_state_e;

endpackage

// File: rtl/tv_sync.sv
// Module tv_sync
// Two-flop synchroniser per bit for asynchronous channel health lines.
// Assumes level signals that are held for at least one clock period.
// Reset value is 0, the fail-safe "unhealthy" reading.
module tv_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[g] = stab_q;
        end
    endgenerate

endmodule

// File: rtl/tv_vote.sv
// Module tv_vote
// Two-of-three trip vote on synchronised health, plus a per-channel
// discrepancy monitor with sticky flags.
// Assumes ok_i is already synchronous; clr_i is only pulsed when all
// channels are healthy.
module tv_vote #(
    parameter int DISC_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [tv_pkg::NCH-1:0] ok_i,
    input  logic                  clr_i,
    output logic                  trip_o,
    output logic [tv_pkg::NCH-1:0] disc_o
);

    localparam int DCW = $clog2(DISC_CYCLES + 1);
    localparam logic [DCW-1:0] DISC_LAST = DCW'(DISC_CYCLES - 1);

    // Trip when at least two channels request it (read low)
    always_comb begin
        trip_o = (!ok_i[0] && !ok_i[1]) || (!ok_i[0] && !ok_i[2]) ||
                 (!ok_i[1] && !ok_i[2]);
    end

    genvar g;
    generate
        for (g = 0; g < tv_pkg::NCH; g++) begin : g_chan
            localparam int J = (g + 1) % tv_pkg::NCH;
            localparam int K = (g + 2) % tv_pkg::NCH;
            logic           odd_one;
            logic [DCW-1:0] run_q;
            logic           flag_q;

            // This channel is the odd one out of an agreeing pair
            always_comb begin
                odd_one = (ok_i[J] == ok_i[K]) && (ok_i[g] != ok_i[J]);
            end

            // Count consecutive disagreeing cycles, hold the sticky flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q  <= '0;
                    flag_q <= 1'b0;
                end else begin
                    if (!odd_one) begin
                        run_q <= '0;
                    end else if (run_q != DISC_LAST) begin
                        run_q <= run_q + 1'b1;
                    end
                    if (clr_i) begin
                        flag_q <= 1'b0;
                    end else if (odd_one && run_q == DISC_LAST) begin
                        flag_q <= 1'b1;
                    end
                end
            end
            assign disc_o[g] = flag_q;
        end
    endgenerate

endmodule

// File: rtl/tv_permit_fsm.sv
// Module tv_permit_fsm
// Startup / run / tripped sequencing of the run permit, plus the deadline
// monitor on the permit-drop path.
// Assumes trip_i and all_ok_i come from synchronised channel data.
module tv_permit_fsm #(
    parameter int STARTUP_CYCLES  = 1000,
    parameter int DEADLINE_CYCLES = 1600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              all_ok_i,
    input  logic              trip_i,
    input  logic              rst_req_i,
    output logic              permit_o,
    output tv_pkg::tv_state_e state_o,
    output logic              overrun_o
);
    import tv_pkg::*;

    localparam int SCW = $clog2(STARTUP_CYCLES + 1);
    localparam int DLW = $clog2(DEADLINE_CYCLES + 1);
    localparam logic [SCW-1:0] ST_LAST = SCW'(STARTUP_CYCLES - 1);
    localparam logic [DLW-1:0] DL_LAST = DLW'(DEADLINE_CYCLES - 1);

    tv_state_e      state_q, state_n;
    logic [SCW-1:0] st_cnt_q;
    logic [DLW-1:0] dl_cnt_q;
    logic           permit_q;
    logic           ovr_q;
    logic           accept;
    logic           late;

    assign accept = rst_req_i && all_ok_i;
    assign late   = permit_q && trip_i;

    // Next-state selection
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_START: if (all_ok_i && st_cnt_q == ST_LAST) state_n = ST_RUN;
            ST_RUN:   if (trip_i) state_n = ST_TRIP;
            ST_TRIP:  if (accept) state_n = ST_START;
            default:  state_n = ST_TRIP;
        endcase
    end

    // State, startup counter and registered permit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_START;
            st_cnt_q <= '0;
            permit_q <= 1'b0;
        end else begin
            state_q  <= state_n;
            permit_q <= (state_n == ST_RUN);
            if (state_q == ST_START && all_ok_i) begin
                st_cnt_q <= st_cnt_q + 1'b1;
            end else begin
                st_cnt_q <= '0;
            end
        end
    end

    // Deadline monitor: cycles the permit survives a present trip condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_cnt_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (!late) begin
                dl_cnt_q <= '0;
            end else if (dl_cnt_q != DL_LAST) begin
                dl_cnt_q <= dl_cnt_q + 1'b1;
            end
            if (late && dl_cnt_q == DL_LAST) begin
                ovr_q <= 1'b1;
            end
        end
    end

    assign permit_o  = permit_q;
    assign state_o   = state_q;
    assign overrun_o = ovr_q;

endmodule

// File: rtl/trip_voter.sv
// Module trip_voter
// Top of the two-out-of-three safety trip voter: synchroniser, vote with
// discrepancy monitor, permit sequencer, and the one-way status word.
// Assumes chan_ok_i is asynchronous and fail-safe (low = trip request).
module trip_voter #(
    parameter int DISC_CYCLES     = 64,
    parameter int STARTUP_CYCLES  = 1000,
    parameter int DEADLINE_CYCLES = 1600000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] chan_ok_i,
    input  logic       trip_reset_i,
    output logic       run_permit_o,
    output logic [9:0] status_o
);
    import tv_pkg::*;

    logic [NCH-1:0] ok_s;
    logic [NCH-1:0] disc;
    logic           trip;
    logic           all_ok;
    logic           clr;
    logic           permit;
    logic           ovr;
    tv_state_e      state;

    assign all_ok = &ok_s;
    assign clr    = trip_reset_i && all_ok;

    tv_sync #(.WIDTH(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (chan_ok_i),
        .sync_o  (ok_s)
    );

    tv_vote #(.DISC_CYCLES(DISC_CYCLES)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .ok_i   (ok_s),
        .clr_i  (clr),
        .trip_o (trip),
        .disc_o (disc)
    );

    tv_permit_fsm #(
        .STARTUP_CYCLES  (STARTUP_CYCLES),
        .DEADLINE_CYCLES (DEADLINE_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_ok_i  (all_ok),
        .trip_i    (trip),
        .rst_req_i (trip_reset_i),
        .permit_o  (permit),
        .state_o   (state),
        .overrun_o (ovr)
    );

    // Assemble the read-only status word
    always_comb begin
        status_o                           = '0;
        status_o[SB_PERMIT]                = permit;
        status_o[SB_STATE +: 2]            = state;
        status_o[SB_HEALTH +: NCH]         = ok_s;
        status_o[SB_DISC +: NCH]           = disc;
        status_o[SB_OVR]                   = ovr;
    end

    assign run_permit_o = permit;

endmodule

// File: rtl/tv_checker.sv
// Module tv_checker
// Concurrent properties on the voter's ports, bound to trip_voter.
// Assumes the status layout from tv_pkg (st_i is status bits 9:1).
module tv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       trip_reset_i,
    input logic       run_permit_o,
    input logic [8:0] st_i
);
    logic [1:0] state;
    logic [2:0] health;
    logic [2:0] disc;
    logic       ovr;

    assign state  = st_i[1:0];
    assign health = st_i[4:2];
    assign disc   = st_i[7:5];
    assign ovr    = st_i[8];

    // R2: two or more low channels while running drop the permit next edge
    p_trip_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_permit_o && $countones(health) <= 1) |=> !run_permit_o);

    // R3: with at most one low channel a running permit holds
    p_single_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_permit_o && $countones(health) >= 2) |=> run_permit_o);

    // R4: a trip stays latched unless an accepted reset arrives
    p_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'b10 && !(trip_reset_i && &health))
        |=> (state == 2'b10 && !run_permit_o));

    // R6: the permit only rises from a fully healthy reading
    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_permit_o) |-> (&$past(health) && $past(state) == 2'b00));

    // R7: discrepancy flags are sticky without an accepted reset
    p_disc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(trip_reset_i && &health) |=> ((disc & $past(disc)) == $past(disc)));

    // R8: the deadline monitor never fires
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr);

endmodule

bind trip_voter tv_checker u_tv_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_reset_i (trip_reset_i),
    .run_permit_o (run_permit_o),
    .st_i         (status_o[9:1])
);

// File: tb/trip_voter_test.sv
`timescale 1ns/1ps
module trip_voter_test;

    localparam int DISC  = 12;
    localparam int START = 10;
    localparam int DLIM  = 20;

    typedef struct {
        string      tag;
        logic       p;
        logic [1:0] st;
        logic       hchk;
        logic [2:0] h;
        logic [2:0] d;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] ok;
    logic       trst;
    logic       permit;
    logic [9:0] status;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic [2:0] exp_disc = 3'b000;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    trip_voter #(
        .DISC_CYCLES     (DISC),
        .STARTUP_CYCLES  (START),
        .DEADLINE_CYCLES (DLIM)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_ok_i    (ok),
        .trip_reset_i (trst),
        .run_permit_o (permit),
        .status_o     (status)
    );

    // Driver: expected outputs after the next rising edge
    task automatic chk(input string tag, input logic p, input logic [1:0] st,
                       input logic hchk, input logic [2:0] h);
        exp_t e;
        @(posedge clk);
        #1;
        e.tag = tag; e.p = p; e.st = st; e.hchk = hchk; e.h = h; e.d = exp_disc;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            logic bad;
            e = sb.pop_front();
            n_chk++;
            bad = (permit !== e.p) || (status[0] !== e.p) ||
                  (status[2:1] !== e.st) || (status[8:6] !== e.d) ||
                  (status[9] !== 1'b0) || (e.hchk && status[5:3] !== e.h);
            if (bad) begin
                n_fail++;
                $display("FAIL %s: permit=%b status=%b expected permit=%b state=%b health=%b(chk %b) disc=%b ovr=0",
                         e.tag, permit, status, e.p, e.st, e.h, e.hchk, e.d);
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        ok    = 3'b111;
        trst  = 1'b0;
        run(3);
        #1;
        chk("R9 reset state zero", 1'b0, 2'b00, 1'b1, 3'b000);

        @(negedge clk);
        rst_n = 1'b1;
        chk("R6 startup low at first edge", 1'b0, 2'b00, 1'b0, 3'b000);
        run(START - 1);
        chk("R6 startup still low one edge early", 1'b0, 2'b00, 1'b1, 3'b111);
        chk("R6 permit rises after STARTUP_CYCLES", 1'b1, 2'b01, 1'b1, 3'b111);
        chk("R1 synced health visible", 1'b1, 2'b01, 1'b1, 3'b111);

        // R10: reset request while running
        trst = 1'b1;
        chk("R10 reset in run keeps permit", 1'b1, 2'b01, 1'b1, 3'b111);
        trst = 1'b0;
        chk("R10 permit after reset pulse", 1'b1, 2'b01, 1'b1, 3'b111);

        // R3 / R7: long single-channel request on channel 1
        ok = 3'b101;
        run(DISC + 6);
        exp_disc = 3'b010;
        chk("R3 single channel no trip, R7 flag set", 1'b1, 2'b01, 1'b1, 3'b101);
        ok = 3'b111;
        run(4);
        chk("R7 flag sticky after recovery", 1'b1, 2'b01, 1'b1, 3'b111);

        // R7: short glitch on channel 0 sets nothing
        ok = 3'b110;
        run(DISC - 4);
        ok = 3'b111;
        run(4);
        chk("R7 short disagreement no flag", 1'b1, 2'b01, 1'b1, 3'b111);

        // R2 / R4 / R5 / R6 for every trip pattern
        for (int k = 0; k < 4; k++) begin
            logic [2:0] pat;
            case (k)
                0: pat = 3'b100;
                1: pat = 3'b010;
                2: pat = 3'b001;
                default: pat = 3'b000;
            endcase
            ok = pat;
            chk("R2 permit high at edge 1", 1'b1, 2'b01, 1'b0, 3'b000);
            chk("R2 permit high at edge 2, R1 synced", 1'b1, 2'b01, 1'b1, pat);
            chk("R2 permit low at edge 3", 1'b0, 2'b10, 1'b1, pat);
            ok = 3'b111;
            run(5);
            chk("R4 trip latched after recovery", 1'b0, 2'b10, 1'b1, 3'b111);

            ok = 3'b011;
            run(3);
            trst = 1'b1;
            chk("R5 reset ignored with channel low", 1'b0, 2'b10, 1'b1, 3'b011);
            trst = 1'b0;
            run(2);
            chk("R5 still tripped", 1'b0, 2'b10, 1'b1, 3'b011);

            ok = 3'b111;
            run(3);
            trst = 1'b1;
            exp_disc = 3'b000;
            chk("R5 accepted reset enters startup, R7 flags clear", 1'b0, 2'b00, 1'b1, 3'b111);
            trst = 1'b0;

            run(START - 3);
            ok = 3'b110;
            run(1);
            ok = 3'b111;
            run(6);
            chk("R6 startup restarted by low channel", 1'b0, 2'b00, 1'b1, 3'b111);
            run(START + 2);
            chk("R6 permit back after full startup", 1'b1, 2'b01, 1'b1, 3'b111);
        end

        chk("R8 overrun flag clear after all trips", 1'b1, 2'b01, 1'b1, 3'b111);

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule